// File: doc/BRIEF.md
# Parallel Random Bitstream Expander

This block turns two independent one-bit entropy inputs into a word of parallel random bits. Every clock it takes one sample from each input and pushes it into a shift register of its own. Each output bit is formed by a single XOR of one stage from the first register with one stage from the second register. The first register's tap moves to older stages as the output index rises. The second register's tap moves to newer stages at the same time. Because the two taps move in opposite directions, the age difference between the two samples is different for every output. As a result, no two output bits, in the same cycle or in different cycles, are built from the same pair of samples. Two samples may still appear together in one pair only once, although one sample may be used by several outputs.

A build-time option removes the second source. In that variant the far end of the first register feeds the second register, and the two registers act as one long delay chain. The output word is registered. A valid flag rises only when every tap in use holds a sample taken after reset. The entropy sources themselves are outside the block, and so is any trimming of their bias.

Top module: `rand_fanout`

## Requirements
- R1: A synchronous, active-high `rst` clears both registers and the output word to zero and holds `rnd_valid` low. After any edge at which `rst` is high, `rnd_out` is 0 and `rnd_valid` is 0.
- R2: A single 1 applied on `ent_a` while all other samples are 0 appears on output i (bit i-1 of `rnd_out`) exactly i edges after it was sampled, and never on the other outputs.
- R3: Number the rising edges after `rst` is released from 1, and let A(k) and B(k) be the values sampled on `ent_a` and `ent_b` at edge k. Treat every sample with k < 1 as 0. After edge m, output i (1-based, bit i-1, 1 ≤ i ≤ N_OUT) equals A(m-i) XOR B(m-N_OUT+i-1).
- R4: With two sources, `rnd_valid` is low after edges 1 to N_OUT. It is high after edge N_OUT+1 and after every later edge until `rst` is asserted again.
- R5: When the parameter CHAIN is 1, `ent_b` has no effect. The second register's input is the last stage of the first register, so B(k) = A(k-N_OUT) in the formula of R3.
- R6: When CHAIN is 1, `rnd_valid` rises after edge 2*N_OUT+1 and stays high until reset.
- R7: Asserting reset in the middle of a stream discards all earlier samples. After release, outputs follow R3 with pre-reset samples read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_a | input | 1 | First entropy input, sampled every edge |
| ent_b | input | 1 | Second entropy input; ignored when CHAIN=1 |
| rnd_out | output | N_OUT | Registered random output word, bit i-1 is output i |
| rnd_valid | output | 1 | High when every tap in use holds a post-reset sample |

## Verification
Two things change on the edge where `rnd_valid` first goes high. The flag itself rises, and output 1's B tap and output N_OUT's A tap reach their first fresh sample. The bench makes both visible on that edge by driving random data from the first cycle after release, so that a tap misplaced by one stage gives a non-zero mismatch exactly when the flag rises. A reset is also asserted in the middle of a running stream, so that the clearing of the registers and the shifting of new data fall on adjacent edges. A behavioural model built from sample histories judges every edge for both the two-source and the chained variant.

// File: rtl/rand_fanout.sv
`timescale 1ns/1ps
module rand_fanout #(
  parameter int N_OUT = 4,
  parameter bit CHAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ent_a,
  input  logic             ent_b,
  output logic [N_OUT-1:0] rnd_out,
  output logic             rnd_valid
);
  localparam int FILL = CHAIN ? 2 * N_OUT + 1 : N_OUT + 1;
  localparam int CW   = $clog2(FILL + 1);

  logic [N_OUT-1:0] sa, sb, mix;
  logic             b_in;
  logic [CW-1:0]    fill_cnt;

  generate
    if (CHAIN) begin : g_chain
      assign b_in = sa[N_OUT-1] | (ent_b & 1'b0);
    end else begin : g_dual
      assign b_in = ent_b;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa[0] <= ent_a;
      sb[0] <= b_in;
      for (int k = 1; k < N_OUT; k++) begin
        sa[k] <= sa[k-1];
        sb[k] <= sb[k-1];
      end
    end
  end

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_mix
      assign mix[i] = sa[i] ^ sb[N_OUT-1-i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_out  <= '0;
      fill_cnt <= '0;
    end else begin
      rnd_out <= mix;
      if (fill_cnt != CW'(FILL)) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign rnd_valid = (fill_cnt == CW'(FILL));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rnd_out == '0 && !rnd_valid));

  p_a_entry_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sa[0] == $past(ent_a));

  p_valid_hold_r4: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |=> rnd_valid);

  p_valid_not_early_r4: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> !$past(rst));

  generate
    if (CHAIN) begin : g_chk_chain
      p_chain_feed_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sb[0] == $past(sa[N_OUT-1]));
    end else begin : g_chk_dual
      p_b_entry_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sb[0] == $past(ent_b));
    end
  endgenerate
endmodule

// File: tb/rand_fanout_bench.sv
`timescale 1ns/1ps
module rand_fanout_bench;
  localparam int ND = 4;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ent_a = 1'b0, ent_b = 1'b0;
  logic [ND-1:0] out_d;
  logic [NC-1:0] out_c;
  logic val_d, val_c;

  int checks = 0, errs = 0, m = 0;
  bit qa[$];
  bit qb[$];
  string tag = "R3";

  always #2 clk = ~clk;

  rand_fanout #(.N_OUT(ND), .CHAIN(1'b0)) u_rand_fanout (
    .clk(clk), .rst(rst), .ent_a(ent_a), .ent_b(ent_b),
    .rnd_out(out_d), .rnd_valid(val_d));

  rand_fanout #(.N_OUT(NC), .CHAIN(1'b1)) u_chain (
    .clk(clk), .rst(rst), .ent_a(ent_a), .ent_b(ent_b),
    .rnd_out(out_c), .rnd_valid(val_c));

  function automatic bit ga(int k);
    return (k < 1) ? 1'b0 : qa[k];
  endfunction
  function automatic bit gb(int k);
    return (k < 1) ? 1'b0 : qb[k];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", req, what, m, act, exp);
    end
  endtask

  task automatic tick(bit r, bit a, bit b);
    logic [ND-1:0] ed;
    logic [NC-1:0] ec;
    @(negedge clk);
    rst = r; ent_a = a; ent_b = b;
    @(posedge clk);
    if (r) begin
      m = 0;
      qa.delete(); qb.delete();
      qa.push_back(1'b0); qb.push_back(1'b0);
    end else begin
      m++;
      qa.push_back(a); qb.push_back(b);
    end
    #1;
    if (r) begin
      chk(out_d == '0 && !val_d, "R1", "dual reset state", {out_d, val_d}, 0);
      chk(out_c == '0 && !val_c, "R1", "chain reset state", {out_c, val_c}, 0);
    end else begin
      for (int i = 1; i <= ND; i++) ed[i-1] = ga(m-i) ^ gb(m-ND+i-1);
      for (int i = 1; i <= NC; i++) ec[i-1] = ga(m-i) ^ ga(m-NC+i-1-NC);
      chk(out_d == ed, tag, "dual output word", out_d, ed);
      chk(val_d == (m >= ND+1), "R4", "dual valid", val_d, (m >= ND+1));
      chk(out_c == ec, "R5", "chain output word", out_c, ec);
      chk(val_c == (m >= 2*NC+1), "R6", "chain valid", val_c, (m >= 2*NC+1));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errs++;
    $display("FAIL watchdog expired at edge %0d: actual=hung expected=done", m);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 3; c++) tick(1'b1, 1'b1, 1'b1);
    tag = "R3";
    for (int c = 0; c < 40; c++) tick(1'b0, 1'($urandom), 1'($urandom));
    for (int c = 0; c < 10; c++) tick(1'b0, 1'b1, 1'b1);
    tick(1'b1, 1'b0, 1'b0);
    tag = "R2";
    for (int c = 0; c < 3; c++) tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    for (int c = 0; c < 12; c++) tick(1'b0, 1'b0, 1'b0);
    tag = "R3";
    for (int c = 0; c < 20; c++) tick(1'b0, 1'($urandom), 1'b0);
    for (int c = 0; c < 20; c++) tick(1'b0, 1'b0, 1'($urandom));
    for (int c = 0; c < 15; c++) tick(1'b0, 1'($urandom), 1'($urandom));
    for (int c = 0; c < 2; c++) tick(1'b1, 1'($urandom), 1'($urandom));
    tag = "R7";
    for (int c = 0; c < 30; c++) tick(1'b0, 1'($urandom), 1'($urandom));
    finish_run();
  end
endmodule